// File: doc/BRIEF.md
# Floating-Point Exception Status and Interrupt Controller

This block sits between a host CPU and a floating-point arithmetic datapath. The CPU starts an operation with a load strobe. The block passes that strobe to the datapath when the unit is idle and holds a busy state until the datapath reports completion. It then gives the CPU a one-cycle ready pulse. Along with its completion strobe, the datapath presents five exception indications. They are recorded on every completed operation, whatever the mask says.

The recorded conditions are kept in sticky status flags. Software reads them through a small register port and clears them by writing ones. A software-writable mask register holds one bit per exception. A registered interrupt request goes high whenever a flag is set and its mask bit is clear. Masking therefore only gates the interrupt. The flags are recorded either way.

Top module: `fpx_exc_ctrl`

## Requirements
- R1: After reset, all flags read 0, all mask bits read 1, and irq_o, busy_o and ready_o are 0.
- R2: A load_i while busy_o is 0 asserts dp_start_o in the same cycle, and busy_o reads 1 from the next cycle. A load_i while busy_o is 1 is ignored: dp_start_o stays 0.
- R3: A dp_done_i while busy_o is 1 gives a single-cycle ready_o in the next cycle, and busy_o returns to 0 in that same cycle. A dp_done_i while idle is ignored: no ready_o and no flag change.
- R4: On an accepted completion, dp_exc_i is ORed into the flags whatever the mask. The bit order is 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact.
- R5: A set flag stays set through later operations that report no exception.
- R6: With reg_addr_i=0, reg_rdata_o shows the flags. With reg_addr_i=1, it shows the mask. The value is combinational and current.
- R7: A write (reg_we_i=1) to address 0 clears each flag whose reg_wdata_i bit is 1 and leaves the flags whose bit is 0 unchanged.
- R8: If a recorded exception and a software clear target the same flag in the same cycle, the flag ends up set.
- R9: A write to address 1 replaces the mask with reg_wdata_i from the next cycle.
- R10: irq_o equals the OR of (flags AND NOT mask) as they stood one cycle earlier. It rises one cycle after a flag sets or after a set flag is unmasked, and falls one cycle after the cause is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | CPU strobe to start an operation |
| busy_o | output | 1 | Operation in flight |
| dp_start_o | output | 1 | Start strobe to the datapath |
| dp_done_i | input | 1 | Datapath completion strobe |
| dp_exc_i | input | 5 | Exception indications valid with dp_done_i |
| ready_o | output | 1 | Result-valid pulse to the CPU |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | 0 selects flags, 1 selects mask |
| reg_wdata_i | input | 5 | Write data (ones to clear for flags) |
| reg_rdata_o | output | 5 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
A behavioural model runs beside the design and compares every output on every cycle.

Directed sequences cover the cases that separate the features:
- A flagged operation under the reset mask shows that recording does not depend on masking.
- A clean operation after it shows stickiness.
- Unmasking an already-set flag shows the one-cycle interrupt delay.
- A zero write versus a one write to the flag address tells write-one-to-clear apart from plain writes.
- A clear issued in the same cycle as a completion shows that the set wins.

Stray loads while busy and stray completions while idle show that the handshake rejects them. A long random mix of operations, exception patterns and register writes then exercises the interactions.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned NUM_EXC = 5;

  typedef enum int unsigned {
    EXC_INVALID  = 0,
    EXC_DIVZERO  = 1,
    EXC_OVERFLOW = 2,
    EXC_UNDERFLW = 3,
    EXC_INEXACT  = 4
  } exc_idx_e;

  localparam logic ADDR_FLAGS = 1'b0;
  localparam logic ADDR_MASK  = 1'b1;
endpackage

// File: rtl/fpx_handshake.sv
module fpx_handshake #(
  parameter int unsigned NEXC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            dp_done_i,
  input  logic [NEXC-1:0] dp_exc_i,
  output logic            dp_start_o,
  output logic            busy_o,
  output logic            ready_o,
  output logic [NEXC-1:0] exc_set_o
);
  logic busy_q, ready_q;
  logic accept_done;

  assign accept_done = dp_done_i & busy_q;
  assign dp_start_o  = load_i & ~busy_q;
  assign exc_set_o   = accept_done ? dp_exc_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= accept_done;
      if (accept_done)     busy_q <= 1'b0;
      else if (dp_start_o) busy_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = ready_q;

  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_start_o |=> busy_o);
  a_r3_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r3_done_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_done_i && busy_o) |=> (ready_o && !busy_o));
endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg #(
  parameter int unsigned NEXC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXC-1:0] set_i,
  input  logic [NEXC-1:0] clr_i,
  output logic [NEXC-1:0] flag_o
);
  logic [NEXC-1:0] flag_q;

  // per-bit: set has priority over write-one-to-clear
  for (genvar i = 0; i < NEXC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & clr_i) != '0) |=> ((flag_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));
  a_r4_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fpx_mask_reg.sv
module fpx_mask_reg #(
  parameter int unsigned NEXC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NEXC-1:0] wdata_i,
  output logic [NEXC-1:0] mask_o
);
  logic [NEXC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mask_o == $past(wdata_i)));
  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/fpx_irq_gen.sv
module fpx_irq_gen #(
  parameter int unsigned NEXC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXC-1:0] flag_i,
  input  logic [NEXC-1:0] mask_i,
  output logic            irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & ~mask_i);
  end

  assign irq_o = irq_q;

  a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & ~mask_i) != '0) |=> irq_o);
  a_r10_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & ~mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/fpx_exc_ctrl.sv
module fpx_exc_ctrl
  import fpx_pkg::*;
#(
  parameter int unsigned NEXC = fpx_pkg::NUM_EXC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  output logic            busy_o,
  output logic            dp_start_o,
  input  logic            dp_done_i,
  input  logic [NEXC-1:0] dp_exc_i,
  output logic            ready_o,
  input  logic            reg_we_i,
  input  logic            reg_addr_i,
  input  logic [NEXC-1:0] reg_wdata_i,
  output logic [NEXC-1:0] reg_rdata_o,
  output logic            irq_o
);
  logic [NEXC-1:0] exc_set, flag_clr, flags, mask;
  logic            mask_we;

  assign flag_clr = (reg_we_i && reg_addr_i == ADDR_FLAGS) ? reg_wdata_i : '0;
  assign mask_we  = reg_we_i && reg_addr_i == ADDR_MASK;

  fpx_handshake #(.NEXC(NEXC)) u_hs (
    .clk_i, .rst_ni, .load_i, .dp_done_i, .dp_exc_i,
    .dp_start_o, .busy_o, .ready_o, .exc_set_o(exc_set)
  );

  fpx_flag_reg #(.NEXC(NEXC)) u_flags (
    .clk_i, .rst_ni, .set_i(exc_set), .clr_i(flag_clr), .flag_o(flags)
  );

  fpx_mask_reg #(.NEXC(NEXC)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we), .wdata_i(reg_wdata_i), .mask_o(mask)
  );

  fpx_irq_gen #(.NEXC(NEXC)) u_irq (
    .clk_i, .rst_ni, .flag_i(flags), .mask_i(mask), .irq_o
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_MASK) ? mask : flags;

  a_r3_idle_done_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_done_i && !busy_o && !reg_we_i) |=> ($stable(flags) && !ready_o));
  a_r2_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !dp_start_o);
endmodule

// File: tb/tb_fpx_exc_ctrl.sv
`timescale 1ns/1ps
module tb_fpx_exc_ctrl;
  localparam int NEXC = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0, dp_done_i = 1'b0, reg_we_i = 1'b0, reg_addr_i = 1'b0;
  logic [NEXC-1:0] dp_exc_i = '0, reg_wdata_i = '0;
  logic busy_o, dp_start_o, ready_o, irq_o;
  logic [NEXC-1:0] reg_rdata_o;

  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  fpx_exc_ctrl dut (
    .clk_i, .rst_ni, .load_i, .busy_o, .dp_start_o, .dp_done_i, .dp_exc_i,
    .ready_o, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  // behavioural reference
  logic m_busy = 0, m_ready = 0, m_irq = 0;
  logic [NEXC-1:0] m_flags = '0, m_mask = '1;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_ready = 0; m_irq = 0; m_flags = '0; m_mask = '1;
    end else begin
      automatic logic acc = dp_done_i && m_busy;
      automatic logic [NEXC-1:0] setv = acc ? dp_exc_i : '0;
      automatic logic [NEXC-1:0] clrv = (reg_we_i && !reg_addr_i) ? reg_wdata_i : '0;
      m_irq   = (m_flags & ~m_mask) != 0;
      m_ready = acc;
      if (acc) m_busy = 0;
      else if (load_i) m_busy = 1;
      m_flags = (m_flags & ~clrv) | setv;
      if (reg_we_i && reg_addr_i) m_mask = reg_wdata_i;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk("R2 busy", busy_o, m_busy);
    chk("R2 dp_start", dp_start_o, load_i && !m_busy);
    chk("R3 ready", ready_o, m_ready);
    chk("R6 rdata", reg_rdata_o, reg_addr_i ? m_mask : m_flags);
    chk("R10 irq", irq_o, m_irq);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic run_op(logic [NEXC-1:0] exc, int lat);
    load_i = 1; cyc(); load_i = 0;
    cyc(lat);
    dp_done_i = 1; dp_exc_i = exc; cyc();
    dp_done_i = 0; dp_exc_i = '0;
  endtask

  task automatic rd(logic a, output logic [NEXC-1:0] v);
    reg_addr_i = a; #1; v = reg_rdata_o;
  endtask

  task automatic wr(logic a, logic [NEXC-1:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; cyc();
    reg_we_i = 0; reg_wdata_i = '0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NEXC-1:0] v;
    cyc(3); rst_ni = 1; cyc();
    rd(0, v); chk("R1 flags reset", v, 0);
    rd(1, v); chk("R1 mask reset", v, 5'h1f);
    chk("R1 irq reset", irq_o, 0);
    chk("R1 busy reset", busy_o, 0);

    // invalid exception under full mask: recorded, no irq
    run_op(5'b00001, 2);
    chk("R3 ready pulse", ready_o, 1);
    rd(0, v); chk("R4 invalid recorded while masked", v, 5'b00001);
    cyc(); chk("R10 masked no irq", irq_o, 0);
    chk("R3 ready single", ready_o, 0);

    // load while busy ignored
    load_i = 1; cyc(); #1 chk("R2 load while busy ignored", dp_start_o, 0);
    cyc(); load_i = 0;
    dp_done_i = 1; dp_exc_i = 5'b10000; cyc(); dp_done_i = 0; dp_exc_i = 0;
    rd(0, v); chk("R4 inexact bit4", v, 5'b10001);

    // done while idle ignored
    cyc(2);
    dp_done_i = 1; dp_exc_i = 5'b00110; cyc(); dp_done_i = 0; dp_exc_i = 0;
    chk("R3 idle done no ready", ready_o, 0);
    rd(0, v); chk("R3 idle done no flags", v, 5'b10001);

    // sticky
    run_op(5'b00000, 1);
    rd(0, v); chk("R5 sticky after clean op", v, 5'b10001);

    // unmask set flag -> irq one cycle later
    wr(1, 5'b11110);
    chk("R10 irq not same cycle", irq_o, 0);
    rd(1, v); chk("R9 mask written", v, 5'b11110);
    cyc(); chk("R10 irq after unmask", irq_o, 1);

    // w1c
    wr(0, 5'b00000);
    rd(0, v); chk("R7 zero write keeps", v, 5'b10001);
    wr(0, 5'b00001);
    rd(0, v); chk("R7 clear bit0", v, 5'b10000);
    cyc(); chk("R10 irq drops", irq_o, 0);

    // set beats clear
    load_i = 1; cyc(); load_i = 0; cyc();
    dp_done_i = 1; dp_exc_i = 5'b00100;
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 5'b10100; cyc();
    dp_done_i = 0; dp_exc_i = 0; reg_we_i = 0; reg_wdata_i = 0;
    rd(0, v); chk("R8 set wins over clear", v, 5'b00100);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      load_i      = ($urandom % 4) == 0;
      dp_done_i   = ($urandom % 3) == 0;
      dp_exc_i    = $urandom;
      reg_we_i    = ($urandom % 5) == 0;
      reg_addr_i  = $urandom;
      reg_wdata_i = $urandom;
      cyc();
    end
    load_i = 0; dp_done_i = 0; reg_we_i = 0;
    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule